// File: doc/BRIEF.md
# Wakeup Change-Detect Status Unit

This unit watches four asynchronous external interrupt lines. A line that changes level in either direction sets its own bit in a sticky status register. Reading the status register returns its contents and clears it. A read/write mask register selects which recorded changes may raise one registered wakeup request. A higher-level interrupt controller takes that request as its power-management event bit.

Each line passes through a two-flop synchroniser. Edges are found by comparing the synchronised level with its value one cycle earlier. The status register records every change, whether or not the line is masked. The mask only gates the wakeup request. Software can therefore leave a device masked while the device powers down and still see its line activity. After reset the mask is all ones, so nothing can wake the system until software clears mask bits. Edge detection stays off for the first three cycles after reset. During that time the synchroniser fills, so a line held high through reset is not reported as a change.

Top module: `wake_change_detect`

## Requirements
- R1: After reset, a read at address 0x7F2C (status) returns 0x00, and `wake` is 0.
- R2: A rising edge and a falling edge on line n (irq_in[n]) each set status bit n. Line n maps to bit n for n = 0..3.
- R3: A status read returns the bits collected since the previous status read. After the read, those bits are 0.
- R4: A change whose edge is detected in the same cycle as a status read is not returned by that read. It stays set afterwards.
- R5: The mask is at address 0x7F2D and resets to 0x0F. A write sets bits 3:0 from wdata[3:0]. Bits 7:4 of the mask and of the status register always read as 0.
- R6: `wake` is a registered level. It is 1 while any status bit n is 1 and its mask bit n is 0. It falls after the status bits are cleared by a read or masked.
- R7: Changes on masked lines are still recorded in the status register.
- R8: Writes to the status address leave the status register unchanged.
- R9: A line held at a constant level through reset and after it does not set its status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the addressed register |
| irq_in | input | 4 | Raw asynchronous external lines |
| wake | output | 1 | Registered wakeup request |

## Verification
The first patterns are single rising and single falling edges on one line at a time. They show that both directions are detected and that each line reaches its own bit. Random multi-line toggles are then mixed with random mask writes and status reads. These separate sticky accumulation from clear-on-read, and recording from wakeup gating. Directed cases cover three situations:
- a change on a masked line, which must be recorded without raising `wake`;
- an edge that lands in the same cycle as a status read, which must survive the read;
- a nonzero level held through reset, which must not report a change.

// File: rtl/wake_change_detect.sv
module wake_change_detect #(
  parameter int AW = 16,
  parameter int NL = 4,
  parameter int DW = 8,
  parameter logic [AW-1:0] STAT_ADDR = 16'h7F2C,
  parameter logic [AW-1:0] MASK_ADDR = 16'h7F2D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NL-1:0] irq_in,
  output logic          wake
);
  localparam int PAD = DW - NL;

  logic [NL-1:0] sync1, sync2, prev, stat, mask, chg;
  logic [1:0]    warm;
  logic          armed, stat_sel, mask_sel, stat_rd, mask_wr;

  assign armed    = (warm == 2'd3);
  assign chg      = armed ? (sync2 ^ prev) : '0;
  assign stat_sel = (addr == STAT_ADDR);
  assign mask_sel = (addr == MASK_ADDR);
  assign stat_rd  = rd & stat_sel;
  assign mask_wr  = wr & mask_sel;

  assign rdata = stat_sel ? {{PAD{1'b0}}, stat} :
                 mask_sel ? {{PAD{1'b0}}, mask} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
      warm  <= '0;
      stat  <= '0;
      mask  <= '1;
      wake  <= 1'b0;
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
      prev  <= sync2;
      if (!armed) warm <= warm + 2'd1;
      stat  <= (stat_rd ? '0 : stat) | chg;
      if (mask_wr) mask <= wdata[NL-1:0];
      wake  <= |(stat & ~mask);
    end
  end
endmodule

// File: rtl/wake_change_detect_chk.sv
module wake_change_detect_chk #(
  parameter int AW = 16,
  parameter int NL = 4,
  parameter int DW = 8,
  parameter logic [AW-1:0] STAT_ADDR = 16'h7F2C,
  parameter logic [AW-1:0] MASK_ADDR = 16'h7F2D
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd,
  input logic          wr,
  input logic [DW-1:0] rdata,
  input logic [NL-1:0] stat,
  input logic [NL-1:0] mask,
  input logic [NL-1:0] chg,
  input logic          wake
);
  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:NL] == '0);

  assert_clear_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == STAT_ADDR) |=> ((stat & ~$past(chg)) == '0));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && addr == STAT_ADDR) |=> ((stat & $past(stat)) == $past(stat)));

  assert_edge_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(chg)) == $past(chg)));

  assert_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == STAT_ADDR && !rd) |=> ((stat & ~($past(stat) | $past(chg))) == '0));

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1 && $past(mask) == '1) |-> !wake);
endmodule

bind wake_change_detect wake_change_detect_chk #(
  .AW(AW), .NL(NL), .DW(DW), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .rdata(rdata),
  .stat(stat), .mask(mask), .chg(chg), .wake(wake)
);

// File: tb/tb_wake_change_detect.sv
module tb_wake_change_detect;
  localparam logic [15:0] SA = 16'h7F2C;
  localparam logic [15:0] MA = 16'h7F2D;

  logic clk = 0, rst_n = 0, rd = 0, wr = 0, wake;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [3:0] irq_in = 4'b1010;
  int total = 0, bad = 0;
  logic [3:0] exp_stat = '0, exp_mask = 4'hF;
  logic [7:0] got;

  always #2 clk = ~clk;

  wake_change_detect dut (.clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .wake(wake));

  function automatic logic exp_wake(input logic [3:0] s, input logic [3:0] m);
    return |(s & ~m);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1;
    #1 d = rdata;
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic toggle(input logic [3:0] t);
    @(negedge clk); irq_in = irq_in ^ t;
    exp_stat = exp_stat | t;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk("R1 wake reset", {7'd0, wake}, 8'h00);
    rd_reg(SA, got); chk("R1 R9 status after reset", got, 8'h00);
    rd_reg(MA, got); chk("R5 mask reset", got, 8'h0F);

    toggle(4'b0001); rd_reg(SA, got); chk("R2 rising", got, 8'h01); exp_stat = 0;
    toggle(4'b0001); rd_reg(SA, got); chk("R2 falling", got, 8'h01); exp_stat = 0;
    toggle(4'b0010); rd_reg(SA, got); chk("R2 falling line1", got, 8'h02); exp_stat = 0;

    toggle(4'b0100);
    chk("R7 masked no wake", {7'd0, wake}, 8'h00);
    rd_reg(SA, got); chk("R7 masked recorded", got, 8'h04); exp_stat = 0;
    rd_reg(SA, got); chk("R3 cleared", got, 8'h00);

    wr_reg(SA, 8'hFF);
    rd_reg(SA, got); chk("R8 status write ignored", got, 8'h00);
    wr_reg(MA, 8'hF6);
    rd_reg(MA, got); chk("R5 mask rw", got, 8'h06);
    exp_mask = 4'h6;

    toggle(4'b0010);
    @(negedge clk); irq_in = irq_in ^ 4'b1000;
    @(negedge clk); @(negedge clk);
    addr = SA; rd = 1; #1 got = rdata;
    @(posedge clk); #1 rd = 0;
    chk("R4 read returns old", got, 8'h02);
    rd_reg(SA, got); chk("R4 edge kept", got, 8'h08);
    exp_stat = 0;

    wr_reg(MA, 8'h00); exp_mask = 0;
    toggle(4'b1000);
    chk("R6 wake high", {7'd0, wake}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R6 wake holds", {7'd0, wake}, 8'h01);
    wr_reg(MA, 8'h08); exp_mask = 4'h8;
    repeat (2) @(negedge clk);
    chk("R6 wake masked", {7'd0, wake}, 8'h00);
    rd_reg(SA, got); chk("R3 status", got, 8'h08); exp_stat = 0;

    for (int i = 0; i < 300; i++) begin
      case ($urandom % 5)
        0, 1: begin
          toggle(4'($urandom));
          chk("R6 random wake", {7'd0, wake}, {7'd0, exp_wake(exp_stat, exp_mask)});
        end
        2: begin
          rd_reg(SA, got); chk("R3 random status", got, {4'd0, exp_stat});
          exp_stat = 0;
          repeat (2) @(negedge clk);
          chk("R6 wake after clear", {7'd0, wake}, 8'h00);
        end
        3: begin
          logic [7:0] d;
          d = 8'($urandom);
          wr_reg(MA, d); exp_mask = d[3:0];
          repeat (2) @(negedge clk);
          chk("R6 wake after mask", {7'd0, wake}, {7'd0, exp_wake(exp_stat, exp_mask)});
        end
        default: begin
          wr_reg(SA, 8'($urandom));
          rd_reg(MA, got); chk("R5 random mask", got, {4'd0, exp_mask});
          rd_reg(SA, got); chk("R8 random status", got, {4'd0, exp_stat});
          exp_stat = 0;
        end
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule